// File: doc/BRIEF.md
# Set-Associative Data Cache with Selectable Write Policy

This block is a small N-way set-associative data cache. It sits between a word-wide CPU load/store port and a word-wide memory port. Each byte address is cut into a tag, a set index and a word offset inside a block. The index picks one set, and every way of that set compares its stored tag with the request tag at the same time. A read hit returns its word in the cycle the request is presented. A miss picks a victim way. If that victim holds modified data it is copied out first, and then the whole aligned block is fetched from memory one word at a time.

The `WRITE_BACK` parameter selects the write policy. When it is 1, stores change only the cache line and mark it dirty, and memory is updated when the line is evicted. When it is 0, every store also writes its word to memory, and the CPU waits for that write to finish. A store that misses fills the line first and then writes into it.

On the CPU side, `cpu_valid` and the request fields are held until `cpu_ready` pulses for one cycle. That pulse is the only back-pressure. On the memory side, `mem_req` and its fields are held until `mem_ack` is seen high at a clock edge, and each ack moves one word.

Top module: `sa_cache`

## Requirements
- R1: `cpu_ready` is high only while `cpu_valid` is high. It marks completion for exactly one clock edge. The CPU holds `cpu_valid`, `cpu_write`, `cpu_addr` and `cpu_wdata` unchanged until that edge.
- R2: The address is split as follows, with the default parameters: bits [1:0] are zero, bits [3:2] select the word, bits [5:4] select the set, and bits [11:6] are the tag. All ways of the set compare in parallel, and at most one way matches.
- R3: A way hits only when its valid bit is 1 and its tag matches. A read hit sets `cpu_ready` in the same cycle that the request is presented, with no memory request.
- R4: Each line has exactly one valid bit and one dirty bit. A line is never dirty unless it is valid.
- R5: A miss fetches the B-word aligned block that holds the address. It makes one read per word, in ascending address order.
- R6: With write-back, a store hit completes in the cycle it is presented. It does not touch memory, and it marks the line dirty.
- R7: With write-back, a dirty victim is written to memory as B words in ascending order before the refill starts. A clean victim causes no memory write.
- R8: The victim is the lowest-numbered invalid way of the set. If every way is valid, the victim is the way named by the set's round-robin pointer, and the pointer then moves to the next way.
- R9: A store miss first evicts or fills the chosen line, then writes the store data into it. Later reads of that address return the stored data.
- R10: With write-through, each store updates the line and writes that single word to memory. `cpu_ready` rises only in the cycle the write is acknowledged. Lines never become dirty, so evictions never write memory.
- R11: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged from the moment the request is raised until `mem_ack`.
- R12: Reset clears every valid bit, every dirty bit and every round-robin pointer. While idle, no memory request is raised.
- R13: A read always returns the value most recently stored to that address, or the memory contents if the address has never been stored to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_valid | input | 1 | CPU request present |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address, word aligned |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Access completes at this edge |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_ready` on a load |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory has taken or returned the word |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |

## Verification
The assertions rely on a few input rules. The CPU keeps its request fields steady from `cpu_valid` until `cpu_ready`, and every address is word aligned. Memory raises `mem_ack` only while `mem_req` is high. The bench drives each access through one task that sets all the fields at once and releases them only after the completion edge. Random addresses are built from separate tag, set and word fields with the low two bits at zero. The memory model acknowledges only an active request, after a random wait of zero to two cycles, and it counts any request that changes before its ack.

// File: rtl/sa_cache_pkg.sv
`timescale 1ns/1ps
package sa_cache_pkg;
  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_EVICT = 2'd1,
    CS_FILL  = 2'd2,
    CS_THRU  = 2'd3
  } ctl_state_t;
endpackage

// File: rtl/cache_tag_array.sv
`timescale 1ns/1ps
module cache_tag_array #(
  parameter int WAYS     = 2,
  parameter int SETS     = 4,
  parameter int TAG_BITS = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(SETS)-1:0]       lk_set,
  input  logic [TAG_BITS-1:0]           lk_tag,
  output logic                          hit,
  output logic [$clog2(WAYS)-1:0]       hit_way,
  output logic [WAYS-1:0]               set_valid,
  output logic [WAYS-1:0]               set_dirty,
  input  logic [$clog2(WAYS)-1:0]       sel_way,
  output logic [TAG_BITS-1:0]           sel_tag,
  input  logic                          inval_en,
  input  logic                          alloc_en,
  input  logic                          dirty_en,
  input  logic [$clog2(WAYS)-1:0]       upd_way,
  input  logic [TAG_BITS-1:0]           alloc_tag
);
  localparam int WAY_BITS = $clog2(WAYS);

  logic [SETS-1:0][WAYS-1:0] valid_q;
  logic [SETS-1:0][WAYS-1:0] dirty_q;
  logic [TAG_BITS-1:0]       tag_q [SETS][WAYS];
  logic [WAYS-1:0]           match;

  // parallel compare, one comparator per way
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) hit_way = WAY_BITS'(w);
    end
  end

  assign hit       = |match;
  assign set_valid = valid_q[lk_set];
  assign set_dirty = dirty_q[lk_set];
  assign sel_tag   = tag_q[lk_set][sel_way];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (inval_en) begin
        valid_q[lk_set][upd_way] <= 1'b0;
        dirty_q[lk_set][upd_way] <= 1'b0;
      end
      if (alloc_en) begin
        valid_q[lk_set][upd_way] <= 1'b1;
        dirty_q[lk_set][upd_way] <= 1'b0;
      end
      if (dirty_en) begin
        dirty_q[lk_set][upd_way] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) tag_q[lk_set][upd_way] <= alloc_tag;
  end

  // R2: never two ways of one set holding the same tag
  a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  // R4: dirty only on a valid line
  a_r4_dirty_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (set_dirty & ~set_valid) == '0);

  // R9: a freshly allocated line hits on the held request
  a_r9_alloc_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |=> hit);

  // R12: first cycle out of reset sees an empty set
  a_r12_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (set_valid == '0 && set_dirty == '0));
endmodule

// File: rtl/cache_data_array.sv
`timescale 1ns/1ps
module cache_data_array #(
  parameter int WAYS        = 2,
  parameter int SETS        = 4,
  parameter int BLOCK_WORDS = 4,
  parameter int DATA_W      = 32
) (
  input  logic                           clk,
  input  logic [$clog2(SETS)-1:0]        set_idx,
  input  logic [$clog2(WAYS)-1:0]        rd_way,
  input  logic [$clog2(BLOCK_WORDS)-1:0] rd_word,
  output logic [DATA_W-1:0]              rd_data,
  input  logic                           wr_en,
  input  logic [$clog2(WAYS)-1:0]        wr_way,
  input  logic [$clog2(BLOCK_WORDS)-1:0] wr_word,
  input  logic [DATA_W-1:0]              wr_data
);
  localparam int DEPTH    = SETS * WAYS * BLOCK_WORDS;
  localparam int IDX_BITS = $clog2(DEPTH);

  logic [DATA_W-1:0]   store_q [DEPTH];
  logic [IDX_BITS-1:0] rd_idx;
  logic [IDX_BITS-1:0] wr_idx;

  always_comb begin
    rd_idx = IDX_BITS'((int'(set_idx) * WAYS + int'(rd_way)) * BLOCK_WORDS + int'(rd_word));
    wr_idx = IDX_BITS'((int'(set_idx) * WAYS + int'(wr_way)) * BLOCK_WORDS + int'(wr_word));
  end

  assign rd_data = store_q[rd_idx];

  always_ff @(posedge clk) begin
    if (wr_en) store_q[wr_idx] <= wr_data;
  end
endmodule

// File: rtl/cache_victim_sel.sv
`timescale 1ns/1ps
module cache_victim_sel #(
  parameter int WAYS = 2,
  parameter int SETS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(SETS)-1:0] set_idx,
  input  logic [WAYS-1:0]         set_valid,
  input  logic                    take,
  output logic [$clog2(WAYS)-1:0] victim
);
  localparam int WAY_BITS = $clog2(WAYS);

  logic [WAY_BITS-1:0] rr_q [SETS];
  logic                found;
  logic                all_full;

  assign all_full = &set_valid;

  always_comb begin
    victim = rr_q[set_idx];
    found  = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !set_valid[w]) begin
        victim = WAY_BITS'(w);
        found  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else if (take && all_full) begin
      if (int'(rr_q[set_idx]) == WAYS - 1) rr_q[set_idx] <= '0;
      else                                 rr_q[set_idx] <= rr_q[set_idx] + 1'b1;
    end
  end

  // R8: an empty way is always preferred over a filled one
  a_r8_prefers_empty: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (all_full || !set_valid[victim]));

  // R8: a full-set eviction moves the pointer away from the way just used
  a_r8_pointer_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (take && all_full) |=> (rr_q[$past(set_idx)] != $past(victim)));
endmodule

// File: rtl/sa_cache.sv
`timescale 1ns/1ps
module sa_cache
  import sa_cache_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int WAYS        = 2,   // power of two, at least 2
  parameter int SETS        = 4,   // power of two, at least 2
  parameter int BLOCK_WORDS = 4,   // power of two, at least 2
  parameter bit WRITE_BACK  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int WORD_BITS = $clog2(BLOCK_WORDS);
  localparam int SET_BITS  = $clog2(SETS);
  localparam int WAY_BITS  = $clog2(WAYS);
  localparam int TAG_BITS  = ADDR_W - 2 - WORD_BITS - SET_BITS;
  localparam int TAG_LSB   = 2 + WORD_BITS + SET_BITS;

  ctl_state_t           state_q, state_d;
  logic [WORD_BITS-1:0] cnt_q, cnt_d;
  logic [WAY_BITS-1:0]  vic_way_q;
  logic [TAG_BITS-1:0]  vic_tag_q;

  logic [WORD_BITS-1:0] a_word;
  logic [SET_BITS-1:0]  a_set;
  logic [TAG_BITS-1:0]  a_tag;

  logic                 hit;
  logic [WAY_BITS-1:0]  hit_way;
  logic [WAYS-1:0]      set_valid, set_dirty;
  logic [WAY_BITS-1:0]  victim;
  logic [TAG_BITS-1:0]  victim_tag;
  logic                 take, inval_en, alloc_en, dirty_en, need_evict;
  logic [WAY_BITS-1:0]  upd_way;

  logic [WAY_BITS-1:0]  rd_way, wr_way;
  logic [WORD_BITS-1:0] rd_word, wr_word;
  logic [DATA_W-1:0]    rd_data, wr_data;
  logic                 wr_en;
  logic                 last_word;
  logic                 store_hit;

  assign a_word = cpu_addr[2 +: WORD_BITS];
  assign a_set  = cpu_addr[2 + WORD_BITS +: SET_BITS];
  assign a_tag  = cpu_addr[TAG_LSB +: TAG_BITS];

  assign last_word = &cnt_q;
  assign take      = (state_q == CS_IDLE) && cpu_valid && !hit;
  assign store_hit = (state_q == CS_IDLE) && cpu_valid && hit && cpu_write;
  assign inval_en  = take;
  assign alloc_en  = (state_q == CS_FILL) && mem_ack && last_word;
  assign upd_way   = (state_q == CS_IDLE) ? (take ? victim : hit_way) : vic_way_q;

  // write policy variant
  if (WRITE_BACK) begin : g_wback
    assign dirty_en   = store_hit;
    assign need_evict = set_dirty[victim];
  end else begin : g_wthru
    assign dirty_en   = 1'b0;
    assign need_evict = 1'b0;
  end

  cache_tag_array #(
    .WAYS(WAYS), .SETS(SETS), .TAG_BITS(TAG_BITS)
  ) i_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_set    (a_set),
    .lk_tag    (a_tag),
    .hit       (hit),
    .hit_way   (hit_way),
    .set_valid (set_valid),
    .set_dirty (set_dirty),
    .sel_way   (victim),
    .sel_tag   (victim_tag),
    .inval_en  (inval_en),
    .alloc_en  (alloc_en),
    .dirty_en  (dirty_en),
    .upd_way   (upd_way),
    .alloc_tag (a_tag)
  );

  cache_victim_sel #(
    .WAYS(WAYS), .SETS(SETS)
  ) i_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_idx   (a_set),
    .set_valid (set_valid),
    .take      (take),
    .victim    (victim)
  );

  // data array port muxing
  always_comb begin
    if (state_q == CS_EVICT) begin
      rd_way  = vic_way_q;
      rd_word = cnt_q;
    end else begin
      rd_way  = hit_way;
      rd_word = a_word;
    end
    if (state_q == CS_FILL) begin
      wr_en   = mem_ack;
      wr_way  = vic_way_q;
      wr_word = cnt_q;
      wr_data = mem_rdata;
    end else begin
      wr_en   = store_hit;
      wr_way  = hit_way;
      wr_word = a_word;
      wr_data = cpu_wdata;
    end
  end

  cache_data_array #(
    .WAYS(WAYS), .SETS(SETS), .BLOCK_WORDS(BLOCK_WORDS), .DATA_W(DATA_W)
  ) i_data (
    .clk     (clk),
    .set_idx (a_set),
    .rd_way  (rd_way),
    .rd_word (rd_word),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_way  (wr_way),
    .wr_word (wr_word),
    .wr_data (wr_data)
  );

  assign cpu_rdata = rd_data;

  // control sequence
  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    cpu_ready = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cpu_addr;
    mem_wdata = cpu_wdata;
    unique case (state_q)
      CS_IDLE: begin
        if (cpu_valid) begin
          if (hit) begin
            if (!cpu_write || WRITE_BACK) cpu_ready = 1'b1;
            else                          state_d   = CS_THRU;
          end else begin
            cnt_d   = '0;
            state_d = need_evict ? CS_EVICT : CS_FILL;
          end
        end
      end
      CS_EVICT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {vic_tag_q, a_set, cnt_q, 2'b00};
        mem_wdata = rd_data;
        if (mem_ack) begin
          cnt_d = cnt_q + 1'b1;
          if (last_word) state_d = CS_FILL;
        end
      end
      CS_FILL: begin
        mem_req  = 1'b1;
        mem_addr = {a_tag, a_set, cnt_q, 2'b00};
        if (mem_ack) begin
          cnt_d = cnt_q + 1'b1;
          if (last_word) state_d = CS_IDLE;
        end
      end
      CS_THRU: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) begin
          cpu_ready = 1'b1;
          state_d   = CS_IDLE;
        end
      end
      default: state_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= CS_IDLE;
      cnt_q     <= '0;
      vic_way_q <= '0;
      vic_tag_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (take) begin
        vic_way_q <= victim;
        vic_tag_q <= victim_tag;
      end
    end
  end

  // R1: completion only for a presented request
  a_r1_ready_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_valid);

  // R2: requests arrive word aligned
  a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid |-> (cpu_addr[1:0] == 2'b00));

  // R11: a pending memory request does not change
  a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R5 / R7: block transfers step upward one word at a time
  a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == CS_EVICT || state_q == CS_FILL) && mem_ack && !last_word)
      |=> (mem_req && mem_addr == $past(mem_addr) + ADDR_W'(4)));

  // R6: a write-back store completes without memory traffic
  a_r6_wb_store_local: assert property (@(posedge clk) disable iff (!rst_n)
    (WRITE_BACK && cpu_ready && cpu_write) |-> !mem_req);

  // R10: a write-through store completes on its memory write ack
  a_r10_wt_store_acked: assert property (@(posedge clk) disable iff (!rst_n)
    (!WRITE_BACK && cpu_ready && cpu_write) |-> (mem_req && mem_we && mem_ack));

  // R12: no memory request while idle
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CS_IDLE) |-> !mem_req);
endmodule

// File: tb/test_sa_cache.sv
`timescale 1ns/1ps
module test_mem (
  input  logic        clk,
  input  logic        req,
  input  logic        we,
  input  logic [11:0] addr,
  input  logic [31:0] wdata,
  output logic        ack,
  output logic [31:0] rdata,
  output int          n_rd,
  output int          n_wr,
  output int          n_bad
);
  parameter logic [31:0] SALT = 32'h0;

  logic [31:0] mem [1024];
  logic [11:0] rd_log [8];
  logic [11:0] wr_log [8];
  int          wait_cnt;
  logic        p_req, p_ack, p_we;
  logic [11:0] p_addr;
  logic [31:0] p_wdata;

  function automatic logic [31:0] seed_word(input int i);
    return (32'(i) * 32'h9E37_79B9) ^ SALT;
  endfunction

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = seed_word(i);
    ack = 0; rdata = '0; n_rd = 0; n_wr = 0; n_bad = 0; wait_cnt = 0;
    p_req = 0; p_ack = 0; p_we = 0; p_addr = '0; p_wdata = '0;
  end

  always begin
    @(posedge clk);
    #1;
    if (p_req && !p_ack && (!req || addr != p_addr || we != p_we || (we && wdata != p_wdata)))
      n_bad++;
    ack = 0;
    if (req) begin
      if (wait_cnt == 0) begin
        ack = 1;
        if (we) begin
          mem[addr[11:2]] = wdata;
          wr_log[n_wr % 8] = addr;
          n_wr++;
        end else begin
          rdata = mem[addr[11:2]];
          rd_log[n_rd % 8] = addr;
          n_rd++;
        end
        wait_cnt = int'($urandom % 3);
      end else begin
        wait_cnt--;
      end
    end
    p_req = req; p_ack = ack; p_we = we; p_addr = addr; p_wdata = wdata;
  end
endmodule

module test_sa_cache;
  localparam logic [31:0] SALT0 = 32'h5A5A_0000;
  localparam logic [31:0] SALT1 = 32'h00C3_3C00;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cv [2];
  logic        cw [2];
  logic [11:0] ca [2];
  logic [31:0] cwd [2];
  logic        cr [2];
  logic [31:0] crd [2];
  logic        mreq [2];
  logic        mwe [2];
  logic [11:0] maddr [2];
  logic [31:0] mwdata [2];
  logic        mack [2];
  logic [31:0] mrdata [2];
  int          nrd [2];
  int          nwr [2];
  int          nbad [2];
  logic [31:0] shadow [2][1024];
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;

  sa_cache i_sa_cache (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cv[0]), .cpu_write(cw[0]), .cpu_addr(ca[0]), .cpu_wdata(cwd[0]),
    .cpu_ready(cr[0]), .cpu_rdata(crd[0]),
    .mem_req(mreq[0]), .mem_we(mwe[0]), .mem_addr(maddr[0]), .mem_wdata(mwdata[0]),
    .mem_ack(mack[0]), .mem_rdata(mrdata[0])
  );

  sa_cache #(.WRITE_BACK(1'b0)) i_sa_cache_wt (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cv[1]), .cpu_write(cw[1]), .cpu_addr(ca[1]), .cpu_wdata(cwd[1]),
    .cpu_ready(cr[1]), .cpu_rdata(crd[1]),
    .mem_req(mreq[1]), .mem_we(mwe[1]), .mem_addr(maddr[1]), .mem_wdata(mwdata[1]),
    .mem_ack(mack[1]), .mem_rdata(mrdata[1])
  );

  test_mem #(.SALT(SALT0)) i_mem0 (
    .clk(clk), .req(mreq[0]), .we(mwe[0]), .addr(maddr[0]), .wdata(mwdata[0]),
    .ack(mack[0]), .rdata(mrdata[0]), .n_rd(nrd[0]), .n_wr(nwr[0]), .n_bad(nbad[0])
  );

  test_mem #(.SALT(SALT1)) i_mem1 (
    .clk(clk), .req(mreq[1]), .we(mwe[1]), .addr(maddr[1]), .wdata(mwdata[1]),
    .ack(mack[1]), .rdata(mrdata[1]), .n_rd(nrd[1]), .n_wr(nwr[1]), .n_bad(nbad[1])
  );

  function automatic logic [31:0] init_word(input int i, input logic [31:0] salt);
    return (32'(i) * 32'h9E37_79B9) ^ salt;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // one CPU access on unit u, held until its completion edge
  task automatic op(input int u, input bit wr, input logic [11:0] a, input logic [31:0] wd,
                    output logic [31:0] rd, output int lat, output int drd, output int dwr);
    int r0, w0;
    r0 = nrd[u]; w0 = nwr[u];
    cv[u] = 1; cw[u] = wr; ca[u] = a; cwd[u] = wd;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!cr[u] && lat < 5000);
    rd  = crd[u];
    drd = nrd[u] - r0;
    dwr = nwr[u] - w0;
    if (wr) shadow[u][a[11:2]] = wd;
    @(posedge clk);
    #2;
    cv[u] = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    summary();
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    int lat, dr, dw;
    int mism;
    void'($urandom(32'd20240611));
    for (int u = 0; u < 2; u++) begin
      cv[u] = 0; cw[u] = 0; ca[u] = '0; cwd[u] = '0;
      for (int i = 0; i < 1024; i++) shadow[u][i] = init_word(i, u == 0 ? SALT0 : SALT1);
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cr[0] == 0 && cr[1] == 0, "R1", {31'b0, cr[0]}, 0);
    chk(mreq[0] == 0 && mreq[1] == 0, "R12", {31'b0, mreq[0]}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(mreq[0] == 0 && cr[0] == 0, "R12", {31'b0, mreq[0]}, 0);
    @(posedge clk); #2;

    // R3/R5: first access misses (nothing valid), block 0x010..0x01C fetched upward
    op(0, 0, 12'h014, 0, rd, lat, dr, dw);
    chk(rd == shadow[0][12'h014 >> 2], "R13", rd, shadow[0][12'h014 >> 2]);
    chk(dr == 4 && dw == 0, "R5", dr, 4);
    for (int k = 0; k < 4; k++)
      chk(i_mem0.rd_log[(nrd[0] - 4 + k) % 8] == 12'(12'h010 + 4 * k), "R5",
          {20'b0, i_mem0.rd_log[(nrd[0] - 4 + k) % 8]}, 32'h010 + 4 * k);

    // R3/R2: other word of same block hits in the first cycle
    op(0, 0, 12'h01C, 0, rd, lat, dr, dw);
    chk(lat == 1 && dr == 0, "R3", lat, 1);
    chk(rd == shadow[0][12'h01C >> 2], "R2", rd, shadow[0][12'h01C >> 2]);

    // R6: write-back store hit stays local
    op(0, 1, 12'h018, 32'hDEAD_0018, rd, lat, dr, dw);
    chk(lat == 1 && dr == 0 && dw == 0, "R6", dw, 0);
    chk(i_mem0.mem[12'h018 >> 2] == init_word(12'h018 >> 2, SALT0), "R6",
        i_mem0.mem[12'h018 >> 2], init_word(12'h018 >> 2, SALT0));
    op(0, 0, 12'h018, 0, rd, lat, dr, dw);
    chk(rd == 32'hDEAD_0018, "R6", rd, 32'hDEAD_0018);

    // R8: second tag in set 1 fills the empty way, no write
    op(0, 0, 12'h050, 0, rd, lat, dr, dw);
    chk(dr == 4 && dw == 0, "R8", dw, 0);
    // R7: full set, pointer at way 0 (dirty) -> 4 ascending writes then refill
    op(0, 0, 12'h090, 0, rd, lat, dr, dw);
    chk(dw == 4 && dr == 4, "R7", dw, 4);
    for (int k = 0; k < 4; k++)
      chk(i_mem0.wr_log[(nwr[0] - 4 + k) % 8] == 12'(12'h010 + 4 * k), "R7",
          {20'b0, i_mem0.wr_log[(nwr[0] - 4 + k) % 8]}, 32'h010 + 4 * k);
    chk(i_mem0.mem[12'h018 >> 2] == 32'hDEAD_0018, "R7", i_mem0.mem[12'h018 >> 2], 32'hDEAD_0018);
    chk(rd == shadow[0][12'h090 >> 2], "R2", rd, shadow[0][12'h090 >> 2]);
    // R8: pointer advanced to way 1 (clean tag 1) -> no write
    op(0, 0, 12'h0D0, 0, rd, lat, dr, dw);
    chk(dw == 0 && dr == 4, "R7", dw, 0);
    op(0, 0, 12'h094, 0, rd, lat, dr, dw);
    chk(dr == 0 && lat == 1, "R8", dr, 0);
    op(0, 0, 12'h050, 0, rd, lat, dr, dw);
    chk(dr == 4, "R8", dr, 4);
    op(0, 0, 12'h0D4, 0, rd, lat, dr, dw);
    chk(dr == 0, "R8", dr, 0);

    // R9: store miss allocates then writes
    op(0, 1, 12'h120, 32'hC0FF_0120, rd, lat, dr, dw);
    chk(dr == 4 && dw == 0, "R9", dr, 4);
    op(0, 0, 12'h120, 0, rd, lat, dr, dw);
    chk(rd == 32'hC0FF_0120 && dr == 0, "R9", rd, 32'hC0FF_0120);
    op(0, 0, 12'h124, 0, rd, lat, dr, dw);
    chk(rd == shadow[0][12'h124 >> 2], "R9", rd, shadow[0][12'h124 >> 2]);

    // R10: write-through store miss, memory updated by completion
    op(1, 1, 12'h200, 32'h7777_0200, rd, lat, dr, dw);
    chk(dr == 4 && dw == 1, "R10", dw, 1);
    chk(i_mem1.mem[12'h200 >> 2] == 32'h7777_0200, "R10", i_mem1.mem[12'h200 >> 2], 32'h7777_0200);
    op(1, 1, 12'h204, 32'h7777_0204, rd, lat, dr, dw);
    chk(dr == 0 && dw == 1 && lat > 1, "R10", dw, 1);
    op(1, 0, 12'h000, 0, rd, lat, dr, dw);
    op(1, 0, 12'h040, 0, rd, lat, dr, dw);
    chk(dr == 4 && dw == 0, "R10", dw, 0);

    // R13: random mix on both units
    for (int u = 0; u < 2; u++) begin
      for (int k = 0; k < 300; k++) begin
        logic [11:0] a;
        bit          wr;
        logic [31:0] wd;
        a  = {6'($urandom % 6), 2'($urandom), 2'($urandom), 2'b00};
        wr = ($urandom % 3) == 0;
        wd = $urandom;
        op(u, wr, a, wd, rd, lat, dr, dw);
        if (!wr) chk(rd == shadow[u][a[11:2]], "R13", rd, shadow[u][a[11:2]]);
        else if (u == 0) chk(dw == 0 || dw == 4, "R7", dw, 4);
      end
    end

    mism = 0;
    for (int i = 0; i < 1024; i++) if (i_mem1.mem[i] != shadow[1][i]) mism++;
    chk(mism == 0, "R10", mism, 0);
    chk(nbad[0] == 0 && nbad[1] == 0, "R11", nbad[0] + nbad[1], 0);

    summary();
    $finish;
  end
endmodule